// File: doc/BRIEF.md
# Dual-Clock FIFO Fill-Level Flag Generator

This block produces the status flags for one direction of a FIFO whose writer and reader run on unrelated clocks. It keeps the write pointer in the write clock domain and the read pointer in the read clock domain. Each pointer is Gray coded and crosses into the other domain through a two-stage synchronizer. Each domain works out the fill level from its own pointer and the synchronized copy of the other pointer. The storage array sits beside this block and is addressed through the two address outputs.

The write side drives a ready flag that is low when the memory is full. It also drives an active-low almost-full flag, with its threshold set by an offset Y. The read side drives a not-empty flag and an active-low almost-empty flag, with its threshold set by an offset X. A word that a read has moved into the output register no longer counts toward the fill level. A flag becomes active as soon as a local operation pushes the fill level across its threshold. A flag that is released waits until the other side's pointer has passed through both synchronizer stages, which takes two rising edges of the flag's own clock.

Both offsets reset to parameter defaults and can be reloaded at any time, each from the domain that uses it. One asynchronous active-low reset clears both domains, and each domain releases it synchronously.

Top module: `fifo_flag_gen`

## Requirements
- R1: After reset, wr_ready is 1, af_n is 1, ae_n is 0, rd_ready is 0, waddr and raddr are 0, and the offsets hold X = AE_DEF and Y = AF_DEF.
- R2: Once both domains are idle, ae_n is 0 when the fill level (accepted writes minus accepted reads) is at most X, and 1 when it is X+1 or more.
- R3: Once both domains are idle, af_n is 0 when the fill level is at least DEPTH−Y, and 1 when it is DEPTH−(Y+1) or less.
- R4: Once both domains are idle, wr_ready is 0 exactly when the fill level equals DEPTH.
- R5: A write request made while wr_ready is 0 is ignored: waddr does not move and the fill level does not change.
- R6: After a write raises the fill level from X to X+1, ae_n stays 0 through the first rclk rising edge after the write. It is 1 after the second such edge, or after the third when the first edge falls too close to the write.
- R7: After a read lowers the fill level from DEPTH−Y to DEPTH−(Y+1), af_n rises after the second, or at latest the third, wclk rising edge that follows the read.
- R8: After a read from a full memory, wr_ready rises after the second, or at latest the third, wclk rising edge that follows the read.
- R9: Flags become active with no delay. The read edge that brings the fill level down to X drives ae_n to 0, because the word moved to the output register is already excluded from the count. The write edge that reaches DEPTH−Y drives af_n to 0, and the write edge that reaches DEPTH drives wr_ready to 0.
- R10: A pulse on ae_set (rclk) loads X from ae_set_val, and a pulse on af_set (wclk) loads Y from af_set_val. The affected flag shows the new threshold immediately after the loading edge.
- R11: rd_ready is 0 exactly when the idle fill level is 0. A read request made while rd_ready is 0 is ignored, and raddr does not move.
- R12: waddr and raddr are binary addresses of the next location. Each accepted write or read advances its address by one, modulo DEPTH = 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| wclk | input | 1 | Write-domain clock |
| wr_req | input | 1 | Write request; accepted when wr_ready is 1 |
| wr_ready | output | 1 | High while the memory has a free location |
| af_n | output | 1 | Active-low almost-full flag (write domain) |
| waddr | output | AW | Address of the next location to write |
| af_set | input | 1 | Load strobe for offset Y (write domain) |
| af_set_val | input | AW | New value for offset Y |
| rclk | input | 1 | Read-domain clock |
| rd_req | input | 1 | Read request; accepted when rd_ready is 1 |
| rd_ready | output | 1 | High while the memory holds at least one word |
| ae_n | output | 1 | Active-low almost-empty flag (read domain) |
| raddr | output | AW | Address of the next location to read |
| ae_set | input | 1 | Load strobe for offset X (read domain) |
| ae_set_val | input | AW | New value for offset X |

## Verification
If a pointer, a synchronizer stage or an offset register holds a wrong value, the threshold flags disagree with the fill level counted from accepted operations. This shows up within two clock edges of the domain concerned, and the error persists until both sides fall idle. If the Gray encoding or decoding is wrong, the release points shift, so flags release at the wrong fill level or at the wrong edge after an operation on the other side. A broken accept gate shows up at once as an address that moves while the memory is full or empty. It also leaves a fill level that the idle checks no longer match.

// File: rtl/ffg_pkg.sv
package ffg_pkg;
  // Widest pointer handled by the conversion helpers; narrower pointers
  // are zero-extended, which leaves the low bits of both codes intact.
  localparam int PTR_MAX = 16;

  function automatic logic [PTR_MAX-1:0] b2g(input logic [PTR_MAX-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_MAX-1:0] g2b(input logic [PTR_MAX-1:0] g);
    logic [PTR_MAX-1:0] b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/ffg_rst_sync.sv
module ffg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n = sh_q[1];
endmodule

// File: rtl/ffg_sync2.sv
module ffg_sync2 #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/ffg_ptr.sv
module ffg_ptr #(
  parameter int AW = 8,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [PW-1:0] bin_q,
  output logic [PW-1:0] gray_q
);
  import ffg_pkg::*;

  logic [PW-1:0] bin_d;
  logic [PW-1:0] gray_d;

  always_comb begin
    bin_d  = bin_q + PW'(inc);
    gray_d = PW'(b2g(PTR_MAX'(bin_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (inc) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end
endmodule

// File: rtl/ffg_wside.sv
module ffg_wside #(
  parameter int AW      = 8,
  parameter int OFF_DEF = 8,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] wbin,
  input  logic [PW-1:0] rgray_s,
  input  logic          off_we,
  input  logic [AW-1:0] off_val,
  output logic          ready,
  output logic          af_n
);
  import ffg_pkg::*;

  localparam logic [PW-1:0] DEPTH_P = {1'b1, {AW{1'b0}}};

  logic [AW-1:0] off_q;
  logic [AW-1:0] off_d;
  logic [PW-1:0] fill;
  logic [PW-1:0] limit;

  always_comb begin
    off_d = off_we ? off_val : off_q;
    fill  = wbin - PW'(g2b(PTR_MAX'(rgray_s)));
    limit = DEPTH_P - {1'b0, off_q};
    ready = (fill != DEPTH_P);
    af_n  = (fill < limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= AW'(OFF_DEF);
    else        off_q <= off_d;
  end
endmodule

// File: rtl/ffg_rside.sv
module ffg_rside #(
  parameter int AW      = 8,
  parameter int OFF_DEF = 8,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] rbin,
  input  logic [PW-1:0] wgray_s,
  input  logic          off_we,
  input  logic [AW-1:0] off_val,
  output logic          avail,
  output logic          ae_n
);
  import ffg_pkg::*;

  logic [AW-1:0] off_q;
  logic [AW-1:0] off_d;
  logic [PW-1:0] fill;

  always_comb begin
    off_d = off_we ? off_val : off_q;
    fill  = PW'(g2b(PTR_MAX'(wgray_s))) - rbin;
    avail = (fill != '0);
    ae_n  = (fill > {1'b0, off_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= AW'(OFF_DEF);
    else        off_q <= off_d;
  end
endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen #(
  parameter int AW     = 8,
  parameter int AE_DEF = 8,
  parameter int AF_DEF = 8
) (
  input  logic          arst_n,
  input  logic          wclk,
  input  logic          wr_req,
  output logic          wr_ready,
  output logic          af_n,
  output logic [AW-1:0] waddr,
  input  logic          af_set,
  input  logic [AW-1:0] af_set_val,
  input  logic          rclk,
  input  logic          rd_req,
  output logic          rd_ready,
  output logic          ae_n,
  output logic [AW-1:0] raddr,
  input  logic          ae_set,
  input  logic [AW-1:0] ae_set_val
);
  localparam int PW = AW + 1;

  logic          wrst_n;
  logic          rrst_n;
  logic          w_acc;
  logic          r_acc;
  logic [PW-1:0] wbin_q;
  logic [PW-1:0] wgray_q;
  logic [PW-1:0] rbin_q;
  logic [PW-1:0] rgray_q;
  logic [PW-1:0] wgray_r2;
  logic [PW-1:0] rgray_w2;

  ffg_rst_sync u_wrst (.clk(wclk), .arst_n(arst_n), .rst_n(wrst_n));
  ffg_rst_sync u_rrst (.clk(rclk), .arst_n(arst_n), .rst_n(rrst_n));

  // Write domain
  assign w_acc = wr_req & wr_ready;

  ffg_ptr #(.AW(AW)) u_wptr (
    .clk(wclk), .rst_n(wrst_n), .inc(w_acc),
    .bin_q(wbin_q), .gray_q(wgray_q)
  );

  ffg_sync2 #(.W(PW)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w2)
  );

  ffg_wside #(.AW(AW), .OFF_DEF(AF_DEF)) u_wside (
    .clk(wclk), .rst_n(wrst_n), .wbin(wbin_q), .rgray_s(rgray_w2),
    .off_we(af_set), .off_val(af_set_val),
    .ready(wr_ready), .af_n(af_n)
  );

  assign waddr = wbin_q[AW-1:0];

  // Read domain
  assign r_acc = rd_req & rd_ready;

  ffg_ptr #(.AW(AW)) u_rptr (
    .clk(rclk), .rst_n(rrst_n), .inc(r_acc),
    .bin_q(rbin_q), .gray_q(rgray_q)
  );

  ffg_sync2 #(.W(PW)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r2)
  );

  ffg_rside #(.AW(AW), .OFF_DEF(AE_DEF)) u_rside (
    .clk(rclk), .rst_n(rrst_n), .rbin(rbin_q), .wgray_s(wgray_r2),
    .off_we(ae_set), .off_val(ae_set_val),
    .avail(rd_ready), .ae_n(ae_n)
  );

  assign raddr = rbin_q[AW-1:0];
endmodule

// File: rtl/ffg_checker.sv
module ffg_checker #(
  parameter int AW = 8,
  localparam int PW = AW + 1
) (
  input logic          wclk,
  input logic          rclk,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          wr_req,
  input logic          wr_ready,
  input logic          af_n,
  input logic [AW-1:0] waddr,
  input logic          af_set,
  input logic          rd_req,
  input logic          rd_ready,
  input logic          ae_n,
  input logic [AW-1:0] raddr,
  input logic          ae_set,
  input logic [PW-1:0] wgray_r2,
  input logic [PW-1:0] rgray_w2
);
  p_empty_is_almost_empty_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_ready |-> !ae_n);

  p_full_is_almost_full_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    !wr_ready |-> !af_n);

  p_no_overflow_r5: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_req && !wr_ready) |=> $stable(waddr));

  p_no_underflow_r11: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_req && !rd_ready) |=> $stable(raddr));

  p_waddr_step_r12: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_req && wr_ready) |=> (waddr == AW'($past(waddr) + 1'b1)));

  p_raddr_step_r12: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_req && rd_ready) |=> (raddr == AW'($past(raddr) + 1'b1)));

  // ae_n rises only on an arrival from the write side or an offset load
  p_ae_release_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(ae_n) |-> (!$stable(wgray_r2) || $past(ae_set)));

  p_af_release_r7: assert property (@(posedge wclk) disable iff (!wrst_n)
    $rose(af_n) |-> (!$stable(rgray_w2) || $past(af_set)));

  p_ready_release_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
    $rose(wr_ready) |-> !$stable(rgray_w2));
endmodule

bind fifo_flag_gen ffg_checker #(.AW(AW)) u_ffg_chk (
  .wclk(wclk), .rclk(rclk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .wr_req(wr_req), .wr_ready(wr_ready), .af_n(af_n), .waddr(waddr),
  .af_set(af_set), .rd_req(rd_req), .rd_ready(rd_ready), .ae_n(ae_n),
  .raddr(raddr), .ae_set(ae_set), .wgray_r2(wgray_r2), .rgray_w2(rgray_w2)
);

// File: tb/test_fifo_flag_gen.sv
`timescale 1ns/1ps
module test_fifo_flag_gen;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int XD    = 8;
  localparam int YD    = 8;

  logic          arst_n;
  logic          wclk;
  logic          rclk;
  logic          wr_req;
  logic          rd_req;
  logic          af_set;
  logic          ae_set;
  logic [AW-1:0] af_set_val;
  logic [AW-1:0] ae_set_val;
  logic          wr_ready;
  logic          af_n;
  logic          rd_ready;
  logic          ae_n;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;

  int wr_total;
  int rd_total;
  int xo;
  int yo;
  int n_cmp;
  int n_bad;
  bit done;

  fifo_flag_gen #(.AW(AW), .AE_DEF(XD), .AF_DEF(YD)) i_fifo_flag_gen (
    .arst_n(arst_n), .wclk(wclk), .wr_req(wr_req), .wr_ready(wr_ready),
    .af_n(af_n), .waddr(waddr), .af_set(af_set), .af_set_val(af_set_val),
    .rclk(rclk), .rd_req(rd_req), .rd_ready(rd_ready), .ae_n(ae_n),
    .raddr(raddr), .ae_set(ae_set), .ae_set_val(ae_set_val)
  );

  initial begin
    wclk = 1'b0;
    forever #5 wclk = ~wclk;
  end

  initial begin
    rclk = 1'b0;
    forever #7.15 rclk = ~rclk;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    n_cmp++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  function automatic int exp_ae(input int fill, input int x);
    return (fill > x) ? 1 : 0;
  endfunction

  function automatic int exp_af(input int fill, input int y);
    return (fill >= DEPTH - y) ? 0 : 1;
  endfunction

  task automatic settle();
    repeat (4) @(posedge rclk);
    repeat (4) @(posedge wclk);
    #2;
  endtask

  task automatic check_settled(input string ctx);
    int fill;
    fill = wr_total - rd_total;
    chk({"R5 fill within depth ", ctx}, int'(fill >= 0 && fill <= DEPTH), 1);
    chk({"R4 wr_ready ", ctx}, int'(wr_ready), int'(fill < DEPTH));
    chk({"R3 af_n ", ctx}, int'(af_n), exp_af(fill, yo));
    chk({"R2 ae_n ", ctx}, int'(ae_n), exp_ae(fill, xo));
    chk({"R11 rd_ready ", ctx}, int'(rd_ready), int'(fill > 0));
    chk({"R12 waddr ", ctx}, int'(waddr), wr_total % DEPTH);
    chk({"R12 raddr ", ctx}, int'(raddr), rd_total % DEPTH);
  endtask

  task automatic do_writes(input int n);
    bit acc;
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_req = 1'b1;
      acc = wr_ready;
      @(posedge wclk);
      if (acc) wr_total++;
    end
    @(negedge wclk);
    wr_req = 1'b0;
  endtask

  task automatic do_reads(input int n);
    bit acc;
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      rd_req = 1'b1;
      acc = rd_ready;
      @(posedge rclk);
      if (acc) rd_total++;
    end
    @(negedge rclk);
    rd_req = 1'b0;
  endtask

  task automatic goto_fill(input int target);
    int fill;
    fill = wr_total - rd_total;
    if (target > fill) do_writes(target - fill);
    else if (target < fill) do_reads(fill - target);
    settle();
  endtask

  task automatic set_x(input int v);
    @(negedge rclk);
    ae_set = 1'b1;
    ae_set_val = AW'(v);
    @(posedge rclk);
    ae_set <= 1'b0;
    xo = v;
    @(negedge rclk);
  endtask

  task automatic set_y(input int v);
    @(negedge wclk);
    af_set = 1'b1;
    af_set_val = AW'(v);
    @(posedge wclk);
    af_set <= 1'b0;
    yo = v;
    @(negedge wclk);
  endtask

  task automatic one_write();
    @(negedge wclk);
    wr_req = 1'b1;
    @(posedge wclk);
    wr_total++;
    wr_req <= 1'b0;
  endtask

  task automatic one_read();
    @(negedge rclk);
    rd_req = 1'b1;
    @(posedge rclk);
    rd_total++;
    rd_req <= 1'b0;
  endtask

  // R6: count rclk edges from the write until ae_n releases
  task automatic lat_ae();
    int n;
    bit seen;
    goto_fill(xo);
    chk("R2 ae_n low at fill X", int'(ae_n), 0);
    one_write();
    n = 0;
    seen = 1'b0;
    while (n < 6 && !seen) begin
      @(posedge rclk);
      n++;
      @(negedge rclk);
      if (ae_n) seen = 1'b1;
    end
    chk_rng("R6 ae_n release rclk edges", n, 2, 3);
    settle();
  endtask

  // R7: count wclk edges from the read until af_n releases
  task automatic lat_af();
    int n;
    bit seen;
    goto_fill(DEPTH - yo);
    chk("R3 af_n low at fill DEPTH-Y", int'(af_n), 0);
    one_read();
    n = 0;
    seen = 1'b0;
    while (n < 6 && !seen) begin
      @(posedge wclk);
      n++;
      @(negedge wclk);
      if (af_n) seen = 1'b1;
    end
    chk_rng("R7 af_n release wclk edges", n, 2, 3);
    settle();
  endtask

  // R8: count wclk edges from the read until wr_ready releases
  task automatic lat_rdy();
    int n;
    bit seen;
    goto_fill(DEPTH);
    chk("R4 wr_ready low when full", int'(wr_ready), 0);
    one_read();
    n = 0;
    seen = 1'b0;
    while (n < 6 && !seen) begin
      @(posedge wclk);
      n++;
      @(negedge wclk);
      if (wr_ready) seen = 1'b1;
    end
    chk_rng("R8 wr_ready release wclk edges", n, 2, 3);
    settle();
  endtask

  // R9: asserting transitions follow the local edge at once
  task automatic immediate_checks();
    goto_fill(xo + 1);
    chk("R2 ae_n high at fill X+1", int'(ae_n), 1);
    one_read();
    @(negedge rclk);
    chk("R9 ae_n low right after read to X", int'(ae_n), 0);
    settle();
    goto_fill(DEPTH - yo - 1);
    chk("R3 af_n high at DEPTH-Y-1", int'(af_n), 1);
    one_write();
    @(negedge wclk);
    chk("R9 af_n low right after write to DEPTH-Y", int'(af_n), 0);
    settle();
    goto_fill(DEPTH - 1);
    chk("R4 wr_ready high at DEPTH-1", int'(wr_ready), 1);
    one_write();
    @(negedge wclk);
    chk("R9 wr_ready low right after write to DEPTH", int'(wr_ready), 0);
    settle();
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge wclk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed_val;
    int saved;
    arst_n = 1'b0;
    wr_req = 1'b0;
    rd_req = 1'b0;
    af_set = 1'b0;
    ae_set = 1'b0;
    af_set_val = '0;
    ae_set_val = '0;
    wr_total = 0;
    rd_total = 0;
    xo = XD;
    yo = YD;
    n_cmp = 0;
    n_bad = 0;
    seed_val = $urandom(32'd20240611);
    repeat (4) @(posedge wclk);
    #1 arst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 wr_ready after reset", int'(wr_ready), 1);
    chk("R1 af_n after reset", int'(af_n), 1);
    chk("R1 ae_n after reset", int'(ae_n), 0);
    chk("R1 rd_ready after reset", int'(rd_ready), 0);
    chk("R1 waddr after reset", int'(waddr), 0);
    chk("R1 raddr after reset", int'(raddr), 0);

    // R1 default offsets visible at the thresholds
    goto_fill(XD);
    chk("R1 default X, ae_n at X", int'(ae_n), 0);
    goto_fill(XD + 1);
    chk("R1 default X, ae_n at X+1", int'(ae_n), 1);
    goto_fill(DEPTH - YD);
    chk("R1 default Y, af_n at DEPTH-Y", int'(af_n), 0);
    goto_fill(DEPTH - YD - 1);
    chk("R1 default Y, af_n at DEPTH-Y-1", int'(af_n), 1);

    // R11 reads on empty memory are ignored
    goto_fill(0);
    saved = int'(raddr);
    do_reads(5);
    settle();
    chk("R11 raddr unchanged on empty", int'(raddr), saved);
    check_settled("empty reads");

    // R5 writes on full memory are ignored
    goto_fill(DEPTH);
    saved = int'(waddr);
    do_writes(6);
    settle();
    chk("R5 waddr unchanged on full", int'(waddr), saved);
    check_settled("full writes");

    // R10 offset reloading
    goto_fill(20);
    set_x(20);
    chk("R10 ae_n after X=20 at fill 20", int'(ae_n), 0);
    set_x(19);
    chk("R10 ae_n after X=19 at fill 20", int'(ae_n), 1);
    set_y(DEPTH - 20);
    chk("R10 af_n after Y=DEPTH-20 at fill 20", int'(af_n), 0);
    set_y(DEPTH - 21);
    chk("R10 af_n after Y=DEPTH-21 at fill 20", int'(af_n), 1);
    set_x(XD);
    set_y(YD);
    settle();
    check_settled("offsets restored");

    // R6 R7 R8 R9 at several clock phases and offsets
    for (int k = 0; k < 4; k++) begin
      lat_ae();
      lat_af();
      lat_rdy();
      immediate_checks();
      set_x(int'($urandom % 64));
      set_y(int'($urandom % 64));
      repeat (int'($urandom % 5)) @(posedge wclk);
    end

    // Random traffic mix with idle checks of every flag
    for (int it = 0; it < 30; it++) begin
      int unsigned op;
      int a;
      int b;
      op = $urandom % 4;
      a = int'($urandom % 300);
      b = int'($urandom % 300);
      case (op)
        0: do_writes(a);
        1: do_reads(b);
        2: fork
             do_writes(a);
             do_reads(b);
           join
        default: begin
          set_x(int'($urandom % DEPTH));
          set_y(int'($urandom % DEPTH));
          do_writes(a % 40);
        end
      endcase
      settle();
      check_settled("random mix");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule